// File: doc/BRIEF.md
# Eight-Point Fixed-Point Inverse DCT Pass

This block computes one one-dimensional pass of an 8-point integer inverse DCT. It takes eight signed 16-bit coefficients (a row or a column of a dequantized 8x8 block) and produces eight signed 16-bit results. The arithmetic is split into an even half and an odd half, recombined by a final butterfly. All rotation constants are 12-bit fixed point and all accumulation is carried at 32 bits, so the results are bit-exact against an integer software decoder that uses the same factorization.

A single elaboration parameter selects the final narrowing. Column mode narrows with a rounding right shift of 10. Row mode narrows with a truncating right shift of 16. A two-dimensional transform uses one column-mode instance and one row-mode instance, with transposition, level shift and pixel clamping handled outside this block. The result is registered once, so the output appears one clock after the input is accepted.

Top module: `idct8_pass`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is all zeros.
- R2: valid_o equals the value valid_i had at the previous rising clock edge.
- R3: When valid_i is low at a clock edge, data_o keeps its previous value whatever coef_i carries.
- R4: Even half: s26 = in2 + in6; e = s26*K_A; t2 = e + in6*K_B; t3 = e + in2*K_C; t0 = (in0 + in4) << 12; t1 = (in0 - in4) << 12; x0 = t0 + t3; x3 = t0 - t3; x1 = t1 + t2; x2 = t1 - t2. A coefficient vector with only lane 0 nonzero gives eight equal outputs.
- R5: Odd half: a = in1 + in7, b = in3 + in5, c = in3 + in7, d = in1 + in5; m = (a + b)*K_D; p1 = m + a*K_E; p2 = m + b*K_F; p3 = c*K_G; p4 = d*K_H; x4 = p1 + p3 + in7*K_I; x5 = p2 + p4 + in5*K_J; x6 = p2 + p3 + in3*K_K; x7 = p1 + p4 + in1*K_L.
- R6: Recombination: out k = x k + x(7-k) and out(7-k) = x k - x(7-k) for k = 0..3, before narrowing. An all-zero input gives all-zero outputs.
- R7: Column mode (ROW_MODE = 0): each output is (v + 512) arithmetically shifted right by 10, keeping the low 16 bits.
- R8: Row mode (ROW_MODE = 1): each output is v arithmetically shifted right by 16, keeping the low 16 bits, with no rounding.
- R9: Each constant is the signed 16-bit nearest integer to its real coefficient times 4096: K_A 2217 (0.5411961), K_B -7568 (-1.847759065), K_C 3135 (0.765366865), K_D 4816 (1.175875602), K_E -3686 (-0.899976223), K_F -10498 (-2.562915447), K_G -8035 (-1.961570560), K_H -1598 (-0.390180644), K_I 1223 (0.298631336), K_J 8410 (2.053119869), K_K 12586 (3.072711026), K_L 6149 (1.501321110).
- R10: Pairwise pre-additions wrap at 16 bits; products are signed 16x16 to 32 bits; sums, the rounding add and the shift wrap at 32 bits; narrowing truncates with no saturation.
- R11: Lane k of coef_i and data_o occupies bits [16k+15 : 16k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input vector is valid this cycle |
| coef_i | input | 128 | Eight signed 16-bit coefficients, lane k at bits [16k+15:16k] |
| valid_o | output | 1 | Registered result is new |
| data_o | output | 128 | Eight signed 16-bit results, same lane layout |

## Verification
The assertions check on every cycle the one-cycle valid latency, the holding of the output register while no input is accepted, and two structural consequences of the arithmetic: an all-zero vector gives zeros and a lane-0-only vector gives a flat output. The exact numeric behaviour (constant values, 16-bit wrap of the pre-additions, 32-bit wrap of the accumulators, and the difference between rounding and truncating narrowing) can only be shown by the bench scenarios, which compare both modes against an independent model on extreme values, single-lane impulses and random vectors.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
  localparam int DW    = 16;
  localparam int AW    = 32;
  localparam int FRAC  = 12;
  localparam int LANES = 8;
  localparam int HALF  = LANES / 2;

  typedef logic signed [DW-1:0] smp_t;
  typedef logic signed [AW-1:0] acc_t;

  // coefficient * 2^FRAC, rounded to nearest
  localparam smp_t K_A = 16'sd2217;
  localparam smp_t K_B = -16'sd7568;
  localparam smp_t K_C = 16'sd3135;
  localparam smp_t K_D = 16'sd4816;
  localparam smp_t K_E = -16'sd3686;
  localparam smp_t K_F = -16'sd10498;
  localparam smp_t K_G = -16'sd8035;
  localparam smp_t K_H = -16'sd1598;
  localparam smp_t K_I = 16'sd1223;
  localparam smp_t K_J = 16'sd8410;
  localparam smp_t K_K = 16'sd12586;
  localparam smp_t K_L = 16'sd6149;

  function automatic acc_t wmul(input smp_t a, input smp_t b);
    acc_t wa, wb;
    wa = acc_t'(a);
    wb = acc_t'(b);
    return wa * wb;
  endfunction

  function automatic acc_t widen(input smp_t a);
    acc_t w;
    w = acc_t'(a);
    return w <<< FRAC;
  endfunction
endpackage

// File: rtl/idct8_even.sv
module idct8_even
  import idct8_pkg::*;
(
  input  smp_t in0_i,
  input  smp_t in2_i,
  input  smp_t in4_i,
  input  smp_t in6_i,
  output acc_t x0_o,
  output acc_t x1_o,
  output acc_t x2_o,
  output acc_t x3_o
);
  smp_t s26, s04, d04;
  acc_t e_mul, t0, t1, t2, t3;

  always_comb begin
    s26   = in2_i + in6_i;
    e_mul = wmul(s26, K_A);
    t2    = e_mul + wmul(in6_i, K_B);
    t3    = e_mul + wmul(in2_i, K_C);
    s04   = in0_i + in4_i;
    d04   = in0_i - in4_i;
    t0    = widen(s04);
    t1    = widen(d04);
    x0_o  = t0 + t3;
    x3_o  = t0 - t3;
    x1_o  = t1 + t2;
    x2_o  = t1 - t2;
  end
endmodule

// File: rtl/idct8_odd.sv
module idct8_odd
  import idct8_pkg::*;
(
  input  smp_t in1_i,
  input  smp_t in3_i,
  input  smp_t in5_i,
  input  smp_t in7_i,
  output acc_t x4_o,
  output acc_t x5_o,
  output acc_t x6_o,
  output acc_t x7_o
);
  smp_t s17, s35, s37, s15, s_all;
  acc_t m5, p1, p2, p3, p4;

  always_comb begin
    s17   = in1_i + in7_i;
    s35   = in3_i + in5_i;
    s37   = in3_i + in7_i;
    s15   = in1_i + in5_i;
    s_all = s17 + s35;
    m5    = wmul(s_all, K_D);
    p1    = m5 + wmul(s17, K_E);
    p2    = m5 + wmul(s35, K_F);
    p3    = wmul(s37, K_G);
    p4    = wmul(s15, K_H);
    x4_o  = p1 + p3 + wmul(in7_i, K_I);
    x5_o  = p2 + p4 + wmul(in5_i, K_J);
    x6_o  = p2 + p3 + wmul(in3_i, K_K);
    x7_o  = p1 + p4 + wmul(in1_i, K_L);
  end
endmodule

// File: rtl/idct8_narrow.sv
module idct8_narrow
  import idct8_pkg::*;
#(
  parameter bit ROUND = 1'b1,
  parameter int SHIFT = 10
) (
  input  acc_t val_i,
  output smp_t val_o
);
  acc_t biased, shifted;

  generate
    if (ROUND) begin : g_round
      localparam acc_t BIAS = acc_t'(1) <<< (SHIFT - 1);
      assign biased = val_i + BIAS;
    end else begin : g_trunc
      assign biased = val_i;
    end
  endgenerate

  assign shifted = biased >>> SHIFT;
  assign val_o   = smp_t'(shifted);
endmodule

// File: rtl/idct8_pass.sv
module idct8_pass
  import idct8_pkg::*;
#(
  parameter bit ROW_MODE = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [LANES*DW-1:0] coef_i,
  output logic                valid_o,
  output logic [LANES*DW-1:0] data_o
);
  localparam int SHIFT = ROW_MODE ? 16 : 10;
  localparam bit ROUND = !ROW_MODE;

  smp_t in_q  [LANES];
  acc_t x_q   [LANES];
  acc_t sum_q [LANES];
  smp_t res_q [LANES];
  logic [LANES*DW-1:0] res_flat;

  for (genvar k = 0; k < LANES; k++) begin : g_unpack
    assign in_q[k] = smp_t'(coef_i[k*DW +: DW]);
  end

  idct8_even u_even (
    .in0_i(in_q[0]), .in2_i(in_q[2]), .in4_i(in_q[4]), .in6_i(in_q[6]),
    .x0_o (x_q[0]),  .x1_o (x_q[1]),  .x2_o (x_q[2]),  .x3_o (x_q[3])
  );

  idct8_odd u_odd (
    .in1_i(in_q[1]), .in3_i(in_q[3]), .in5_i(in_q[5]), .in7_i(in_q[7]),
    .x4_o (x_q[4]),  .x5_o (x_q[5]),  .x6_o (x_q[6]),  .x7_o (x_q[7])
  );

  for (genvar k = 0; k < HALF; k++) begin : g_bfly
    assign sum_q[k]           = x_q[k] + x_q[LANES-1-k];
    assign sum_q[LANES-1-k]   = x_q[k] - x_q[LANES-1-k];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_narrow
    idct8_narrow #(.ROUND(ROUND), .SHIFT(SHIFT)) u_nar (
      .val_i(sum_q[k]),
      .val_o(res_q[k])
    );
    assign res_flat[k*DW +: DW] = res_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res_flat;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o)); // R3

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && coef_i == '0) |=> data_o == '0); // R6

  for (genvar k = 1; k < LANES; k++) begin : g_dc_chk
    AST_DC_FLAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && coef_i[LANES*DW-1:DW] == '0)
        |=> data_o[k*DW +: DW] == data_o[DW-1:0]); // R4
  end
endmodule

// File: tb/sim_idct8_pass.sv
`timescale 1ns/1ps
module sim_idct8_pass;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         valid_i;
  logic [127:0] coef_i;
  logic         col_valid, row_valid;
  logic [127:0] col_data, row_data;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  idct8_pass #(.ROW_MODE(1'b0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .coef_i(coef_i),
    .valid_o(col_valid), .data_o(col_data));
  idct8_pass #(.ROW_MODE(1'b1)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .coef_i(coef_i),
    .valid_o(row_valid), .data_o(row_data));

  // independent model of R4..R11
  function automatic logic [127:0] ref_pass(input logic [127:0] v, input bit row);
    shortint c[8];
    shortint s26, s04, d04, a, b, cc, d, ab;
    int e, t0, t1, t2, t3, m, p1, p2, p3, p4;
    int x[8];
    int y;
    logic [127:0] r;
    for (int k = 0; k < 8; k++) c[k] = shortint'(v[k*16 +: 16]);
    s26 = shortint'(c[2] + c[6]);
    s04 = shortint'(c[0] + c[4]);
    d04 = shortint'(c[0] - c[4]);
    e  = int'(s26) * 2217;
    t2 = e + int'(c[6]) * -7568;
    t3 = e + int'(c[2]) * 3135;
    t0 = int'(s04) * 4096;
    t1 = int'(d04) * 4096;
    x[0] = t0 + t3; x[3] = t0 - t3; x[1] = t1 + t2; x[2] = t1 - t2;
    a  = shortint'(c[1] + c[7]);
    b  = shortint'(c[3] + c[5]);
    cc = shortint'(c[3] + c[7]);
    d  = shortint'(c[1] + c[5]);
    ab = shortint'(a + b);
    m  = int'(ab) * 4816;
    p1 = m + int'(a) * -3686;
    p2 = m + int'(b) * -10498;
    p3 = int'(cc) * -8035;
    p4 = int'(d) * -1598;
    x[4] = p1 + p3 + int'(c[7]) * 1223;
    x[5] = p2 + p4 + int'(c[5]) * 8410;
    x[6] = p2 + p3 + int'(c[3]) * 12586;
    x[7] = p1 + p4 + int'(c[1]) * 6149;
    for (int k = 0; k < 8; k++) begin
      y = (k < 4) ? x[k] + x[7-k] : x[7-k] - x[k];
      y = row ? (y >>> 16) : ((y + 512) >>> 10);
      r[k*16 +: 16] = y[15:0];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [127:0] v, input string tag);
    logic [127:0] held_c, held_r;
    @(negedge clk_i);
    valid_i = 1'b1;
    coef_i  = v;
    @(negedge clk_i);
    valid_i = 1'b0;
    coef_i  = ~v;
    check({tag, " R2 valid"}, {127'd0, col_valid & row_valid}, 128'd1);
    check({tag, " R7 column"}, col_data, ref_pass(v, 1'b0));
    check({tag, " R8 row"}, row_data, ref_pass(v, 1'b1));
    held_c = col_data;
    held_r = row_data;
    @(negedge clk_i);
    check({tag, " R2 idle"}, {126'd0, col_valid, row_valid}, 128'd0);
    check({tag, " R3 hold"}, {col_data ^ held_c} | {row_data ^ held_r}, 128'd0);
  endtask

  function automatic logic [127:0] fill(input logic [15:0] w);
    return {8{w}};
  endfunction

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    coef_i  = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset col", {127'd0, col_valid} | col_data, 128'd0);
    check("R1 reset row", {127'd0, row_valid} | row_data, 128'd0);
    rst_ni = 1'b1;

    run_vec('0, "zero R6");
    run_vec(128'd100, "dc R4");
    // DC flat outputs and known values: col 400, row 6
    check("dc R4 col value", col_data, fill(16'd400));
    check("dc R4 row value", row_data, fill(16'd6));
    run_vec(128'hFFFF, "dc neg R7 R8");
    for (int k = 0; k < 8; k++) begin
      logic [127:0] imp;
      imp = '0;
      imp[k*16 +: 16] = 16'd1000;
      run_vec(imp, "impulse R11 R9 R5");
    end
    run_vec(fill(16'h7FFF), "max R10");
    run_vec(fill(16'h8000), "min R10");
    run_vec({4{16'h8000, 16'h7FFF}}, "alt R10");
    run_vec({16'h7FFF, 96'd0, 16'h7FFF}, "edge R6");

    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      logic [127:0] rv;
      for (int k = 0; k < 8; k++) begin
        if (i % 3 == 0) rv[k*16 +: 16] = $urandom;
        else rv[k*16 +: 16] = 16'($signed($urandom_range(0, 2047)) - 1024);
      end
      run_vec(rv, "random R4 R5 R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule